// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Demultiplexer

This block sits behind a pin bank whose own change detector can only say that something in a bank of 32 pins moved. On each trigger strobe it receives a fresh sample of every pin. It compares that sample with the copy it kept from the previous trigger and reports which pins actually produced an edge of interest. Each pin has its own enable bit and its own rising and falling select bits. The result is a registered per-pin event vector that is valid for exactly one clock.

The block also drives each bank's change-interrupt enable. When the first pin of an idle bank is enabled, it emits a one-cycle request that clears the bank's pending change. In the same edge it refreshes that bank's stored copy from the live pin levels. The bank enable rises only on the following clock. When the last enabled pin of a bank is disabled, the bank enable drops. Trigger-type writes that ask for a level-sensitive or an unknown mode are refused and flagged.

Top module: `pin_edge_demux`

## Requirements
- R1: After reset, `evt`, `mode_err`, `bank_ie` and `bank_pend_clr` are all 0, and every pin selects no edge: an enabled pin whose trigger type was never written produces no event.
- R2: A pin with rising selected and enabled sets its `evt` bit in the cycle after a `trig_stb` whose level is 1 while its stored previous level is 0.
- R3: A pin with falling selected and enabled sets its `evt` bit in the cycle after a `trig_stb` whose level is 0 while its stored previous level is 1.
- R4: `evt` is the OR of the rising and falling hits. With both edges selected, either direction fires. `evt` is high for exactly one cycle after a strobe and is all zero in any cycle not preceded by a strobe.
- R5: A disabled pin never produces an event, whatever its levels and edge selects.
- R6: Every `trig_stb` replaces the stored previous level of all pins, enabled or not.
- R7: `mode_code` 3'b001 selects rising only, 3'b010 selects falling only and 3'b011 selects both. Every other code is refused: the pin's selects stay unchanged, and `mode_err` is 1 in the cycle after the write and 0 otherwise.
- R8: Setting an enable bit in a bank with no enabled pin pulses that bank's `bank_pend_clr` bit in the next cycle. The same edge loads the bank's stored levels from `pin_lvl`. `bank_ie` for that bank rises one cycle after the pulse.
- R9: Setting an enable bit in a bank that already has an enabled pin produces no `bank_pend_clr` pulse and leaves the stored levels unchanged.
- R10: A bank's `bank_ie` bit is high exactly when that bank had at least one enabled pin one cycle earlier. Clearing the last enabled pin drops it on the second edge after the write; clearing another pin leaves it high.
- R11: Pin p belongs to bank p/32, so pins 31 and 32 fall in banks 0 and 1 and bit b of the bank outputs refers to bank b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_stb | input | 1 | Bank change strobe; `pin_lvl` is valid with it |
| pin_lvl | input | 64 | Sampled pin levels |
| en_we | input | 1 | Enable-bit write strobe |
| en_val | input | 1 | New enable value for `en_pin` |
| en_pin | input | 6 | Pin addressed by the enable write |
| mode_we | input | 1 | Trigger-type write strobe |
| mode_pin | input | 6 | Pin addressed by the trigger-type write |
| mode_code | input | 3 | Trigger type code (see R7) |
| evt | output | 64 | Registered per-pin event vector |
| mode_err | output | 1 | One-cycle flag for a refused trigger type |
| bank_ie | output | 2 | Per-bank change-interrupt enable |
| bank_pend_clr | output | 2 | One-cycle per-bank pending-change clear request |

## Verification
A stale or corrupted stored level stays hidden until the next strobe on that pin. It then appears as a missing or spurious `evt` bit, and only if that pin's selects make the edge count. The stimulus therefore toggles enabled and disabled pins across repeated strobes, so a bad copy shows within one or two triggers. Wrong enable or select bits appear on the first qualifying edge of the affected pin. A wrong per-bank busy state appears on `bank_ie` or `bank_pend_clr` within one or two cycles of an enable write.

// File: rtl/ped_pkg.sv
package ped_pkg;

  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_FALL = 3'b010;
  localparam logic [2:0] TRIG_BOTH = 3'b011;

  typedef struct packed {
    logic ok;
    logic rise;
    logic fall;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] code);
    mode_dec_t d;
    d = '0;
    case (code)
      TRIG_RISE: begin d.ok = 1'b1; d.rise = 1'b1; end
      TRIG_FALL: begin d.ok = 1'b1; d.fall = 1'b1; end
      TRIG_BOTH: begin d.ok = 1'b1; d.rise = 1'b1; d.fall = 1'b1; end
      default:   d = '0;
    endcase
    return d;
  endfunction

  function automatic logic trig_mode_ok(input logic [2:0] code);
    mode_dec_t d;
    d = decode_mode(code);
    return d.ok;
  endfunction

  function automatic logic rise_edge(input logic prev, input logic now,
                                     input logic en, input logic sel);
    return sel & en & ~prev & now;
  endfunction

  function automatic logic fall_edge(input logic prev, input logic now,
                                     input logic en, input logic sel);
    return sel & en & prev & ~now;
  endfunction

endpackage

// File: rtl/ped_mask_regs.sv
module ped_mask_regs #(
  parameter int NPINS  = 64,
  parameter int PIN_IW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              en_val,
  input  logic [PIN_IW-1:0] en_pin,
  input  logic              mode_we,
  input  logic [PIN_IW-1:0] mode_pin,
  input  logic [2:0]        mode_code,
  output logic [NPINS-1:0]  en_q,
  output logic [NPINS-1:0]  rise_q,
  output logic [NPINS-1:0]  fall_q,
  output logic              mode_err
);

  ped_pkg::mode_dec_t dec;
  assign dec = ped_pkg::decode_mode(mode_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      mode_err <= 1'b0;
    end else begin
      mode_err <= mode_we && !dec.ok;
      if (en_we) en_q[en_pin] <= en_val;
      if (mode_we && dec.ok) begin
        rise_q[mode_pin] <= dec.rise;
        fall_q[mode_pin] <= dec.fall;
      end
    end
  end

endmodule

// File: rtl/ped_bank_ctl.sv
module ped_bank_ctl #(
  parameter int NBANKS = 2,
  parameter int BANK_W = 32,
  parameter int PIN_IW = 6,
  localparam int NPINS = NBANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  en_q,
  input  logic              en_we,
  input  logic              en_val,
  input  logic [PIN_IW-1:0] en_pin,
  output logic [NBANKS-1:0] bank_wake,
  output logic [NBANKS-1:0] bank_ie_q,
  output logic [NBANKS-1:0] pend_clr_q
);

  logic [NBANKS-1:0] bank_busy;
  int                tgt_bank;

  assign tgt_bank = int'(en_pin) / BANK_W;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    assign bank_busy[b] = |en_q[b*BANK_W +: BANK_W];
    assign bank_wake[b] = en_we && en_val && (tgt_bank == b) && !bank_busy[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_ie_q  <= '0;
      pend_clr_q <= '0;
    end else begin
      bank_ie_q  <= bank_busy;
      pend_clr_q <= bank_wake;
    end
  end

endmodule

// File: rtl/ped_snapshot.sv
module ped_snapshot #(
  parameter int NBANKS = 2,
  parameter int BANK_W = 32,
  localparam int NPINS = NBANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic [NBANKS-1:0] bank_wake,
  output logic [NPINS-1:0]  snap_q
);

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        snap_q[b*BANK_W +: BANK_W] <= '0;
      end else if (trig || bank_wake[b]) begin
        snap_q[b*BANK_W +: BANK_W] <= pin_lvl[b*BANK_W +: BANK_W];
      end
    end
  end

endmodule

// File: rtl/ped_edge_core.sv
module ped_edge_core #(
  parameter int NPINS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [NPINS-1:0] pin_lvl,
  input  logic [NPINS-1:0] snap_q,
  input  logic [NPINS-1:0] en_q,
  input  logic [NPINS-1:0] rise_q,
  input  logic [NPINS-1:0] fall_q,
  output logic [NPINS-1:0] rise_hit,
  output logic [NPINS-1:0] fall_hit,
  output logic [NPINS-1:0] evt_q
);

  logic [NPINS-1:0] evt_next;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign rise_hit[p] = ped_pkg::rise_edge(snap_q[p], pin_lvl[p], en_q[p], rise_q[p]);
    assign fall_hit[p] = ped_pkg::fall_edge(snap_q[p], pin_lvl[p], en_q[p], fall_q[p]);
  end

  assign evt_next = rise_hit | fall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= trig ? evt_next : '0;
  end

endmodule

// File: rtl/pin_edge_demux.sv
module pin_edge_demux #(
  parameter int NBANKS = 2,
  parameter int BANK_W = 32,
  localparam int NPINS  = NBANKS * BANK_W,
  localparam int PIN_IW = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_stb,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              en_we,
  input  logic              en_val,
  input  logic [PIN_IW-1:0] en_pin,
  input  logic              mode_we,
  input  logic [PIN_IW-1:0] mode_pin,
  input  logic [2:0]        mode_code,
  output logic [NPINS-1:0]  evt,
  output logic              mode_err,
  output logic [NBANKS-1:0] bank_ie,
  output logic [NBANKS-1:0] bank_pend_clr
);

  logic [NPINS-1:0]  en_q;
  logic [NPINS-1:0]  rise_q;
  logic [NPINS-1:0]  fall_q;
  logic [NPINS-1:0]  snap_q;
  logic [NPINS-1:0]  rise_hit;
  logic [NPINS-1:0]  fall_hit;
  logic [NBANKS-1:0] bank_wake;

  ped_mask_regs #(.NPINS(NPINS), .PIN_IW(PIN_IW)) u_masks (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_val(en_val), .en_pin(en_pin),
    .mode_we(mode_we), .mode_pin(mode_pin), .mode_code(mode_code),
    .en_q(en_q), .rise_q(rise_q), .fall_q(fall_q), .mode_err(mode_err)
  );

  ped_bank_ctl #(.NBANKS(NBANKS), .BANK_W(BANK_W), .PIN_IW(PIN_IW)) u_banks (
    .clk(clk), .rst_n(rst_n), .en_q(en_q),
    .en_we(en_we), .en_val(en_val), .en_pin(en_pin),
    .bank_wake(bank_wake), .bank_ie_q(bank_ie), .pend_clr_q(bank_pend_clr)
  );

  ped_snapshot #(.NBANKS(NBANKS), .BANK_W(BANK_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .trig(trig_stb), .pin_lvl(pin_lvl),
    .bank_wake(bank_wake), .snap_q(snap_q)
  );

  ped_edge_core #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .trig(trig_stb), .pin_lvl(pin_lvl),
    .snap_q(snap_q), .en_q(en_q), .rise_q(rise_q), .fall_q(fall_q),
    .rise_hit(rise_hit), .fall_hit(fall_hit), .evt_q(evt)
  );

endmodule

// File: rtl/ped_checker.sv
module ped_checker #(
  parameter int NBANKS = 2,
  parameter int BANK_W = 32,
  localparam int NPINS = NBANKS * BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_stb,
  input logic              mode_we,
  input logic [2:0]        mode_code,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  rise_q,
  input logic [NPINS-1:0]  fall_q,
  input logic [NPINS-1:0]  evt,
  input logic              mode_err,
  input logic [NBANKS-1:0] bank_ie,
  input logic [NBANKS-1:0] bank_pend_clr
);

  // R4
  evt_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |-> $past(trig_stb));

  // R5
  evt_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~$past(en_q)) == '0);

  // R2 R3
  evt_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~($past(rise_q) | $past(fall_q))) == '0);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> ($past(mode_we) && !ped_pkg::trig_mode_ok($past(mode_code))));

  // R7
  rej_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !ped_pkg::trig_mode_ok(mode_code)) |=> ($stable(rise_q) && $stable(fall_q)));

  // R8
  pend_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_pend_clr));

  // R8
  pend_quiet_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_pend_clr & bank_ie) == '0);

  // R8
  pend_then_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_pend_clr != '0) |=> ((bank_ie & $past(bank_pend_clr)) == $past(bank_pend_clr)));

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    // R10
    ie_drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_ie[b]) |-> ($past(en_q[b*BANK_W +: BANK_W]) == '0));
  end

endmodule

bind pin_edge_demux ped_checker #(.NBANKS(NBANKS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_stb(trig_stb), .mode_we(mode_we),
  .mode_code(mode_code), .en_q(en_q), .rise_q(rise_q), .fall_q(fall_q),
  .evt(evt), .mode_err(mode_err), .bank_ie(bank_ie), .bank_pend_clr(bank_pend_clr)
);

// File: tb/pin_edge_demux_bench.sv
module pin_edge_demux_bench;
  localparam int NP = 64;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_stb = 1'b0;
  logic [NP-1:0] pin_lvl = '0;
  logic          en_we = 1'b0, en_val = 1'b0;
  logic [5:0]    en_pin = '0;
  logic          mode_we = 1'b0;
  logic [5:0]    mode_pin = '0;
  logic [2:0]    mode_code = '0;
  logic [NP-1:0] evt;
  logic          mode_err;
  logic [NB-1:0] bank_ie, bank_pend_clr;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // reference state
  logic [NP-1:0] m_en = '0, m_rise = '0, m_fall = '0, m_snap = '0;
  logic [NP-1:0] x_evt = '0;
  logic          x_err = 1'b0;
  logic [NB-1:0] x_ie = '0, x_pc = '0;

  always #5 clk = ~clk;

  pin_edge_demux u_pin_edge_demux (
    .clk(clk), .rst_n(rst_n), .trig_stb(trig_stb), .pin_lvl(pin_lvl),
    .en_we(en_we), .en_val(en_val), .en_pin(en_pin),
    .mode_we(mode_we), .mode_pin(mode_pin), .mode_code(mode_code),
    .evt(evt), .mode_err(mode_err), .bank_ie(bank_ie), .bank_pend_clr(bank_pend_clr)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic code_valid(logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd3);
  endfunction

  // advance the reference by one clock edge from the current inputs
  task automatic model_step();
    logic [NP-1:0] nx_evt;
    nx_evt = '0;
    for (int p = 0; p < NP; p++) begin
      if (trig_stb && m_en[p]) begin
        if (m_rise[p] && pin_lvl[p] && !m_snap[p]) nx_evt[p] = 1'b1;
        if (m_fall[p] && !pin_lvl[p] && m_snap[p]) nx_evt[p] = 1'b1;
      end
    end
    x_evt = nx_evt;
    x_err = mode_we && !code_valid(mode_code);
    for (int b = 0; b < NB; b++) begin
      x_ie[b] = (m_en[b*32 +: 32] != 32'd0);
      x_pc[b] = en_we && en_val && (int'(en_pin) / 32 == b) && !x_ie[b];
    end
    if (trig_stb) m_snap = pin_lvl;
    for (int b = 0; b < NB; b++)
      if (x_pc[b]) m_snap[b*32 +: 32] = pin_lvl[b*32 +: 32];
    if (en_we) m_en[en_pin] = en_val;
    if (mode_we && code_valid(mode_code)) begin
      m_rise[mode_pin] = mode_code[0];
      m_fall[mode_pin] = mode_code[1];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(cur_req, "evt", evt, x_evt);
    check(cur_req, "mode_err", 64'(mode_err), 64'(x_err));
    check(cur_req, "bank_ie", 64'(bank_ie), 64'(x_ie));
    check(cur_req, "bank_pend_clr", 64'(bank_pend_clr), 64'(x_pc));
    trig_stb = 1'b0; en_we = 1'b0; mode_we = 1'b0;
  endtask

  task automatic do_idle();
    tick();
  endtask

  task automatic do_trig(logic [NP-1:0] lv);
    pin_lvl = lv; trig_stb = 1'b1; tick();
  endtask

  task automatic do_en(int pin, logic v);
    en_we = 1'b1; en_val = v; en_pin = 6'(pin); tick();
  endtask

  task automatic do_mode(int pin, logic [2:0] c);
    mode_we = 1'b1; mode_pin = 6'(pin); mode_code = c; tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [NP-1:0] lv;
    void'($urandom(32'h0BADC0DE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "evt reset", evt, '0);
    check("R1", "mode_err reset", 64'(mode_err), 0);
    check("R1", "bank_ie reset", 64'(bank_ie), 0);
    check("R1", "bank_pend_clr reset", 64'(bank_pend_clr), 0);

    // R1 / R8 first enable in idle bank 0
    cur_req = "R8";
    do_en(5, 1'b1);
    check("R8", "pend clr bank0", 64'(bank_pend_clr), 64'h1);
    check("R8", "ie still low", 64'(bank_ie), 0);
    do_idle();
    check("R8", "ie rises", 64'(bank_ie), 64'h1);
    cur_req = "R1";
    lv = '0; lv[5] = 1'b1;
    do_trig(lv);
    check("R1", "no select after reset", evt, '0);

    // R2 rising only
    cur_req = "R2";
    do_mode(5, 3'b001);
    lv[5] = 1'b0; do_trig(lv);
    check("R2", "falling ignored", evt, '0);
    lv[5] = 1'b1; do_trig(lv);
    check("R2", "rising fires", evt, 64'h20);
    do_idle();
    check("R4", "one cycle only", evt, '0);

    // R7 refused codes
    cur_req = "R7";
    do_mode(5, 3'b100);
    check("R7", "err pulse", 64'(mode_err), 1);
    do_mode(5, 3'b000);
    check("R7", "err pulse code0", 64'(mode_err), 1);
    do_idle();
    check("R7", "err clears", 64'(mode_err), 0);
    lv[5] = 1'b0; do_trig(lv);
    check("R7", "still no falling", evt, '0);
    lv[5] = 1'b1; do_trig(lv);
    check("R7", "still rising", evt, 64'h20);

    // R3 falling only
    cur_req = "R3";
    do_mode(5, 3'b010);
    lv[5] = 1'b0; do_trig(lv);
    check("R3", "falling fires", evt, 64'h20);

    // R4 both, plus R9 second pin in busy bank
    cur_req = "R4";
    do_mode(5, 3'b011);
    do_mode(6, 3'b001);
    do_en(6, 1'b1);
    check("R9", "no pend in busy bank", 64'(bank_pend_clr), 0);
    lv[5] = 1'b1; lv[6] = 1'b1; do_trig(lv);
    check("R4", "both rise", evt, 64'h60);
    lv[5] = 1'b0; lv[6] = 1'b0; do_trig(lv);
    check("R4", "fall only on both-pin", evt, 64'h20);

    // R5 / R6 disabled pin still updates stored level
    cur_req = "R6";
    do_en(6, 1'b0);
    lv[6] = 1'b1; do_trig(lv);
    check("R5", "disabled no event", evt, '0);
    do_en(6, 1'b1);
    check("R9", "re-enable no pend", 64'(bank_pend_clr), 0);
    do_trig(lv);
    check("R6", "level captured while disabled", evt, '0);
    lv[6] = 1'b0; do_trig(lv);
    lv[6] = 1'b1; do_trig(lv);
    check("R6", "rise after fresh low", evt, 64'h40);

    // R8 bank 1 resample on first enable
    cur_req = "R8";
    do_trig(lv);
    lv[40] = 1'b1; pin_lvl = lv;
    do_en(40, 1'b1);
    check("R8", "pend clr bank1", 64'(bank_pend_clr), 64'h2);
    do_mode(40, 3'b001);
    check("R8", "ie both banks", 64'(bank_ie), 64'h3);
    do_trig(lv);
    check("R8", "resampled, no rise", evt, '0);

    // R10 last pin off
    cur_req = "R10";
    do_en(40, 1'b0);
    check("R10", "ie holds one more cycle", 64'(bank_ie), 64'h3);
    do_idle();
    check("R10", "ie drops", 64'(bank_ie), 64'h1);

    // R11 bank boundary
    cur_req = "R11";
    do_en(32, 1'b1);
    check("R11", "pin32 in bank1", 64'(bank_pend_clr), 64'h2);
    do_en(31, 1'b1);
    check("R11", "pin31 in bank0", 64'(bank_pend_clr), 0);
    do_en(32, 1'b0);
    do_en(5, 1'b0);
    do_idle();
    check("R10", "bank0 kept by others", 64'(bank_ie), 64'h1);
    check("R11", "bank1 dropped", 64'(bank_ie[1]), 0);

    // mixed random traffic
    cur_req = "R2,R3,R4,R5,R6,R7,R8,R9,R10";
    for (int i = 0; i < 3000; i++) begin
      lv = pin_lvl ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      pin_lvl = lv;
      trig_stb = ($urandom_range(1, 0) == 1);
      if ($urandom_range(4, 0) == 0) begin
        en_we = 1'b1; en_val = ($urandom_range(9, 0) < 6); en_pin = 6'($urandom_range(63, 0));
      end
      if ($urandom_range(4, 0) == 0) begin
        mode_we = 1'b1; mode_pin = 6'($urandom_range(63, 0)); mode_code = 3'($urandom_range(7, 0));
      end
      tick();
    end
    do_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule